// File: doc/BRIEF.md
# DSI Peripheral Response Parser

After a bus turnaround, a display serial host collects the peripheral's reply as 32-bit words in a receive FIFO. This block drains those words and works out what the peripheral said. The first word is a bare status word, which reports either an acknowledge or an escape trigger. The second word is a packet header, classified by its 6-bit data type. From there the block does one of four things. An acknowledge-and-error-report packet yields a 16-bit error vector; for example, bit 5 flags a peripheral timeout, bit 9 a multi-bit ECC fault and bit 15 a protocol violation. A short read response yields one or two bytes straight from the header. A long read response (DCS or generic) yields a payload of bytes unpacked from the words that follow. Any other type is flagged and its remaining words are thrown away.

The caller pulses `start_i` along with two values. The first is the number of words waiting in the FIFO, taken from the FIFO's 5-bit occupancy. The second is the size of the caller's receive buffer. Bytes leave the block one per cycle on `byte_o` with a `byte_valid_o` strobe. The status flags hold their values until the next start. A single-cycle `done_o` marks the point where every word has been consumed and every byte delivered. ECC correction, checksum verification and the PHY are handled elsewhere.

Top module: `dsi_rsp_parser`

## Requirements
- R1: After reset the block is idle: no pop, no byte strobe, no done, and ack, escape, error-valid and bad-type flags are all low.
- R2: The first word of a response sets `ack_o` if it equals 0x84 and `escape_o` if it equals 0x87; any other value sets neither. Flags hold until the next accepted start.
- R3: Header bits 5:0 give the data type and bits 7:6 are ignored. Type 0x02 loads header bits 23:8 into `err_vec_o` and raises `err_valid_o`.
- R4: Type 0x21 emits header bits 15:8. Type 0x22 emits bits 15:8 and then bits 23:16.
- R5: Types 0x1A and 0x1C take the byte count from header bits 23:8. They emit payload from the following words, four bytes per word, starting with bits 7:0.
- R6: The number of bytes emitted is the smallest of three values: the type's byte count, `max_len_i` latched at start, and four times the number of payload words present. The limit applies to short responses too.
- R7: Once no more bytes are due, the words still left in the response are popped and discarded. The total number of pops equals the latched word count.
- R8: Any other data type raises `bad_type_o`, emits no byte, and discards the remaining words.
- R9: `done_o` is a single-cycle pulse once all words are consumed and all bytes are out. A word count of 0 finishes with no pop. A count of 1 consumes only the status word.
- R10: A word is popped only while `fifo_valid_i` is high. Gaps in the FIFO stall the parse without losing or duplicating bytes.
- R11: `start_i` has no effect while a response is being parsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin parsing a response (accepted when idle) |
| word_count_i | input | 5 | Words in the receive FIFO for this response |
| max_len_i | input | 16 | Caller buffer size in bytes |
| fifo_valid_i | input | 1 | FIFO word available |
| fifo_word_i | input | 32 | FIFO head word |
| fifo_pop_o | output | 1 | Consume the FIFO head word this cycle |
| byte_o | output | 8 | Response byte |
| byte_valid_o | output | 1 | `byte_o` is valid this cycle |
| ack_o | output | 1 | Status word was an acknowledge |
| escape_o | output | 1 | Status word was an escape trigger |
| err_vec_o | output | 16 | Error report bits from the header |
| err_valid_o | output | 1 | `err_vec_o` holds a received report |
| bad_type_o | output | 1 | Header data type not recognised |
| done_o | output | 1 | Response fully handled (one-cycle pulse) |

## Verification
The hardest case to reach from the ports is a long response in which three limits compete with one another: the header count, the buffer size and the number of payload words actually present. The difficulty grows when FIFO gaps fall in the middle of a word's bytes and a stray start arrives while the parse is still running. The stimulus builds a 31-word response whose header count exceeds both the buffer limit and what the words can carry. It randomly withholds `fifo_valid_i` and fires a second start with different arguments shortly after the first. Separate cases set each limit to be the smallest one in turn, and a zero count with trailing words checks that draining still happens.

// File: rtl/dsi_rsp_pkg.sv
package dsi_rsp_pkg;
  localparam logic [5:0] DT_ACK_ERR    = 6'h02;
  localparam logic [5:0] DT_DCS_SHORT1 = 6'h21;
  localparam logic [5:0] DT_DCS_SHORT2 = 6'h22;
  localparam logic [5:0] DT_GEN_LONG   = 6'h1A;
  localparam logic [5:0] DT_DCS_LONG   = 6'h1C;
  localparam logic [31:0] STAT_ACK     = 32'h0000_0084;
  localparam logic [31:0] STAT_ESC     = 32'h0000_0087;

  typedef enum logic [1:0] {RK_ACKERR, RK_SHORT, RK_LONG, RK_UNKNOWN} rsp_kind_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_HDR, ST_PAY, ST_EMIT, ST_DRAIN, ST_DONE
  } prs_state_e;
endpackage

// File: rtl/dsi_rsp_classify.sv
module dsi_rsp_classify import dsi_rsp_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic [23:0]      hdr_i,
  output rsp_kind_e        kind_o,
  output logic [LEN_W-1:0] nbytes_o
);
  logic [5:0] dt;
  assign dt = hdr_i[5:0];

  always_comb begin
    kind_o   = RK_UNKNOWN;
    nbytes_o = '0;
    unique case (dt)
      DT_ACK_ERR: kind_o = RK_ACKERR;
      DT_DCS_SHORT1: begin
        kind_o   = RK_SHORT;
        nbytes_o = LEN_W'(1);
      end
      DT_DCS_SHORT2: begin
        kind_o   = RK_SHORT;
        nbytes_o = LEN_W'(2);
      end
      DT_GEN_LONG, DT_DCS_LONG: begin
        kind_o   = RK_LONG;
        nbytes_o = LEN_W'(hdr_i[23:8]);
      end
      default: kind_o = RK_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/dsi_rsp_shifter.sv
module dsi_rsp_shifter #(
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / 8,
  localparam int LANE_W = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic [LANE_W-1:0] load_lanes_i,
  input  logic              shift_i,
  output logic [7:0]        byte_o,
  output logic [LANE_W-1:0] lanes_o
);
  logic [WORD_W-1:0] sh_q;
  logic [LANE_W-1:0] lanes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      lanes_q <= '0;
    end else if (load_i) begin
      sh_q    <= load_word_i;
      lanes_q <= load_lanes_i;
    end else if (shift_i) begin
      sh_q    <= sh_q >> 8;
      lanes_q <= lanes_q - 1'b1;
    end
  end

  assign byte_o  = sh_q[7:0];
  assign lanes_o = lanes_q;

  // R5
  lanes_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lanes_q <= LANE_W'(LANES));
  // R5
  no_empty_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> lanes_q != '0);
endmodule

// File: rtl/dsi_rsp_parser.sv
module dsi_rsp_parser import dsi_rsp_pkg::*; #(
  parameter int CNT_W = 5,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] word_count_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             fifo_valid_i,
  input  logic [31:0]      fifo_word_i,
  output logic             fifo_pop_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic             ack_o,
  output logic             escape_o,
  output logic [15:0]      err_vec_o,
  output logic             err_valid_o,
  output logic             bad_type_o,
  output logic             done_o
);
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES + 1);

  prs_state_e       state_q, state_d;
  logic [CNT_W-1:0] words_q, wl_dec;
  logic [LEN_W-1:0] bytes_q, max_q, bl_init, bl_dec;
  rsp_kind_e        kind;
  logic [LEN_W-1:0] nbytes;
  logic             more, accept, stat_fire, hdr_fire;
  logic             ld, shift;
  logic [WORD_W-1:0] ld_word;
  logic [LANE_W-1:0] ld_lanes, lanes;
  prs_state_e       tail;

  dsi_rsp_classify #(.LEN_W(LEN_W)) u_cls (
    .hdr_i    (fifo_word_i[23:0]),
    .kind_o   (kind),
    .nbytes_o (nbytes)
  );

  dsi_rsp_shifter #(.WORD_W(WORD_W)) u_sh (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (ld),
    .load_word_i  (ld_word),
    .load_lanes_i (ld_lanes),
    .shift_i      (shift),
    .byte_o       (byte_o),
    .lanes_o      (lanes)
  );

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign wl_dec    = words_q - 1'b1;
  assign more      = (wl_dec != '0);
  assign tail      = more ? ST_DRAIN : ST_DONE;
  assign bl_init   = (nbytes < max_q) ? nbytes : max_q;
  assign bl_dec    = bytes_q - 1'b1;
  assign stat_fire = (state_q == ST_STAT) && fifo_valid_i;
  assign hdr_fire  = (state_q == ST_HDR) && fifo_valid_i;

  always_comb begin
    state_d    = state_q;
    fifo_pop_o = 1'b0;
    ld         = 1'b0;
    ld_word    = '0;
    ld_lanes   = '0;
    shift      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (word_count_i == '0) ? ST_DONE : ST_STAT;
      ST_STAT: if (fifo_valid_i) begin
        fifo_pop_o = 1'b1;
        state_d    = more ? ST_HDR : ST_DONE;
      end
      ST_HDR: if (fifo_valid_i) begin
        fifo_pop_o = 1'b1;
        unique case (kind)
          RK_SHORT: begin
            ld       = 1'b1;
            ld_word  = {8'h00, fifo_word_i[31:8]};
            ld_lanes = LANE_W'(LANES - 1);
            state_d  = (bl_init == '0) ? tail : ST_EMIT;
          end
          RK_LONG: state_d = (bl_init == '0 || !more) ? tail : ST_PAY;
          default: state_d = tail;
        endcase
      end
      ST_PAY: if (fifo_valid_i) begin
        fifo_pop_o = 1'b1;
        ld         = 1'b1;
        ld_word    = fifo_word_i;
        ld_lanes   = LANE_W'(LANES);
        state_d    = ST_EMIT;
      end
      ST_EMIT: begin
        shift = 1'b1;
        if (bl_dec == '0 || lanes == LANE_W'(1)) begin
          if (bl_dec != '0 && words_q != '0) state_d = ST_PAY;
          else if (words_q != '0)            state_d = ST_DRAIN;
          else                               state_d = ST_DONE;
        end
      end
      ST_DRAIN: if (fifo_valid_i) begin
        fifo_pop_o = 1'b1;
        if (!more) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      words_q     <= '0;
      bytes_q     <= '0;
      max_q       <= '0;
      ack_o       <= 1'b0;
      escape_o    <= 1'b0;
      err_vec_o   <= '0;
      err_valid_o <= 1'b0;
      bad_type_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        words_q     <= word_count_i;
        max_q       <= max_len_i;
        ack_o       <= 1'b0;
        escape_o    <= 1'b0;
        err_vec_o   <= '0;
        err_valid_o <= 1'b0;
        bad_type_o  <= 1'b0;
      end else if (fifo_pop_o) begin
        words_q <= wl_dec;
      end
      if (stat_fire) begin
        ack_o    <= (fifo_word_i == STAT_ACK);
        escape_o <= (fifo_word_i == STAT_ESC);
      end
      if (hdr_fire) begin
        bytes_q <= bl_init;
        if (kind == RK_ACKERR) begin
          err_vec_o   <= fifo_word_i[23:8];
          err_valid_o <= 1'b1;
        end
        if (kind == RK_UNKNOWN) bad_type_o <= 1'b1;
      end else if (state_q == ST_EMIT) begin
        bytes_q <= bl_dec;
      end
    end
  end

  assign byte_valid_o = (state_q == ST_EMIT);
  assign done_o       = (state_q == ST_DONE);

  // checker bookkeeping
  logic [LEN_W:0]   emit_cnt_q;
  logic [CNT_W:0]   pop_cnt_q;
  logic [CNT_W-1:0] wc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emit_cnt_q <= '0;
      pop_cnt_q  <= '0;
      wc_q       <= '0;
    end else if (accept) begin
      emit_cnt_q <= '0;
      pop_cnt_q  <= '0;
      wc_q       <= word_count_i;
    end else begin
      if (byte_valid_o) emit_cnt_q <= emit_cnt_q + 1'b1;
      if (fifo_pop_o)   pop_cnt_q  <= pop_cnt_q + 1'b1;
    end
  end

  // R6
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> emit_cnt_q < {1'b0, max_q});
  // R7
  pop_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> pop_cnt_q < {1'b0, wc_q});
  // R9
  done_all_popped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pop_cnt_q == {1'b0, wc_q});
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  no_bytes_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> !bad_type_o);
  // R10
  pop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> fifo_valid_i);
  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(max_q) && $stable(wc_q));
endmodule

// File: tb/tb_dsi_rsp_parser.sv
`timescale 1ns/1ps
module tb_dsi_rsp_parser;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  word_count_i = '0;
  logic [15:0] max_len_i = '0;
  logic        fifo_valid_i = 1'b0;
  logic [31:0] fifo_word_i = '0;
  logic        fifo_pop_o, byte_valid_o, ack_o, escape_o, err_valid_o, bad_type_o, done_o;
  logic [7:0]  byte_o;
  logic [15:0] err_vec_o;

  always #4 clk = ~clk;

  dsi_rsp_parser dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .word_count_i(word_count_i),
    .max_len_i(max_len_i), .fifo_valid_i(fifo_valid_i), .fifo_word_i(fifo_word_i),
    .fifo_pop_o(fifo_pop_o), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .ack_o(ack_o), .escape_o(escape_o), .err_vec_o(err_vec_o),
    .err_valid_o(err_valid_o), .bad_type_o(bad_type_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] fifo_q[$];
  logic [31:0] pend[$];
  logic [7:0]  exp_bytes[$];
  bit   e_ack, e_esc, e_errv, e_bad;
  logic [15:0] e_err;
  bit   stall_en = 0;
  bit   consumed = 0;
  bit   done_seen = 0;
  int   cycles = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (consumed && fifo_q.size() > 0) void'(fifo_q.pop_front());
    if (rst_ni && byte_valid_o) begin
      if (exp_bytes.size() == 0) chk(0, "R6 extra byte", byte_o, 0);
      else begin
        logic [7:0] e;
        e = exp_bytes.pop_front();
        chk(byte_o == e, "R5 byte value", byte_o, e);
      end
    end
    if (rst_ni && done_o) done_seen = 1;
    fifo_valid_i = (fifo_q.size() > 0) && !(stall_en && ($urandom % 3 == 0));
    fifo_word_i  = (fifo_q.size() > 0) ? fifo_q[0] : 32'hDEAD_BEEF;
    #1;
    consumed = fifo_pop_o && fifo_valid_i;
  end

  task automatic model(input int maxlen);
    int wc, n;
    logic [31:0] h;
    wc = pend.size();
    exp_bytes.delete();
    e_ack = 0; e_esc = 0; e_errv = 0; e_bad = 0; e_err = '0;
    if (wc >= 1) begin
      e_ack = (pend[0] == 32'h84);
      e_esc = (pend[0] == 32'h87);
    end
    if (wc >= 2) begin
      h = pend[1];
      case (h[5:0])
        6'h02: begin e_errv = 1; e_err = h[23:8]; end
        6'h21: if (maxlen >= 1) exp_bytes.push_back(h[15:8]);
        6'h22: for (int i = 0; i < 2 && i < maxlen; i++) exp_bytes.push_back(h[8*i+8 +: 8]);
        6'h1A, 6'h1C: begin
          n = int'(h[23:8]);
          if (n > maxlen) n = maxlen;
          for (int i = 0; i < n && i < 4*(wc-2); i++)
            exp_bytes.push_back(pend[2 + i/4][8*(i%4) +: 8]);
        end
        default: e_bad = 1;
      endcase
    end
  endtask

  task automatic run_case(input int maxlen, input string tag, input bit mid_start);
    int wc, t;
    model(maxlen);
    wc = pend.size();
    fifo_q = pend;
    done_seen = 0;
    @(negedge clk);
    start_i = 1; word_count_i = 5'(wc); max_len_i = 16'(maxlen);
    @(negedge clk);
    start_i = 0; word_count_i = 5'h1F;
    if (mid_start) begin
      @(negedge clk);
      start_i = 1; word_count_i = 5'(wc ^ 3); max_len_i = 16'd0;
      @(negedge clk);
      start_i = 0;
    end
    t = 0;
    while (!done_seen && t < 4000) begin @(negedge clk); t++; end
    chk(done_seen, {tag, " R9 done seen"}, done_seen, 1);
    @(negedge clk);
    chk(exp_bytes.size() == 0, {tag, " R6 missing bytes"}, exp_bytes.size(), 0);
    chk(fifo_q.size() == 0, {tag, " R7 words left in fifo"}, fifo_q.size(), 0);
    chk(ack_o == e_ack, {tag, " R2 ack"}, ack_o, e_ack);
    chk(escape_o == e_esc, {tag, " R2 escape"}, escape_o, e_esc);
    chk(err_valid_o == e_errv, {tag, " R3 err valid"}, err_valid_o, e_errv);
    chk(err_vec_o == e_err, {tag, " R3 err vec"}, err_vec_o, e_err);
    chk(bad_type_o == e_bad, {tag, " R8 bad type"}, bad_type_o, e_bad);
    chk(done_o == 0 && byte_valid_o == 0, {tag, " R9 done pulse"}, done_o, 0);
    exp_bytes.delete();
  endtask

  task automatic add_payload(input int nw, input logic [31:0] seed);
    for (int k = 0; k < nw; k++) pend.push_back(seed + 32'h0403_0201 * k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(fifo_pop_o == 0 && byte_valid_o == 0 && done_o == 0, "R1 outputs idle", {fifo_pop_o, byte_valid_o, done_o}, 0);
    chk(ack_o == 0 && escape_o == 0 && err_valid_o == 0 && bad_type_o == 0, "R1 flags", {ack_o, escape_o, err_valid_o, bad_type_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    pend.delete(); run_case(8, "R9 zero words", 0);
    pend = '{32'h84}; run_case(8, "R2 ack only", 0);
    pend = '{32'h87}; run_case(8, "R2 escape only", 0);
    pend = '{32'h00}; run_case(8, "R2 neither", 0);
    pend = '{32'h84, 32'h00A5_5A02}; run_case(8, "R3 err report", 0);
    pend = '{32'h84, 32'h0012_80C2}; run_case(8, "R3 vc bits ignored", 0);
    pend = '{32'h84, 32'h0000_3C21}; run_case(8, "R4 short1", 0);
    pend = '{32'h84, 32'h0077_3C22}; run_case(8, "R4 short2", 0);
    pend = '{32'h84, 32'h0077_3C22}; run_case(1, "R6 short2 trunc", 0);
    pend = '{32'h84, 32'h0000_0A1C}; add_payload(3, 32'hA0B0_C0D0); run_case(64, "R5 dcs long", 0);
    pend = '{32'h84, 32'h0000_0A1A}; add_payload(3, 32'h1122_3344); run_case(6, "R7 generic long trunc", 0);
    pend = '{32'h84, 32'h0000_141C}; add_payload(2, 32'h5566_7788); run_case(64, "R6 word limited", 0);
    pend = '{32'h84, 32'h0000_001C}; add_payload(2, 32'h0); run_case(64, "R7 zero count drain", 0);
    pend = '{32'h84, 32'h0000_0215}; add_payload(3, 32'h9999_0000); run_case(64, "R8 unknown type", 0);
    pend = '{32'h84, 32'h0000_0321}; add_payload(2, 32'h7); run_case(64, "R7 short extra words", 0);
    stall_en = 1;
    pend = '{32'h84, 32'h0000_781C}; add_payload(29, 32'h0F1E_2D3C); run_case(100, "R10 R11 stalled long", 1);
    pend = '{32'h87, 32'h0000_091A}; add_payload(3, 32'hCAFE_0000); run_case(9, "R10 stalled exact", 0);
    stall_en = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule